// File: doc/BRIEF.md
# Atomic Scratchpad Memory with Hardware Rings

This block is a small shared word store for message passing and synchronisation between several on-chip requesters. Every request is executed as one indivisible read-modify-write: the addressed word is read in the first busy cycle and written back at the end of it. No other requester can be granted in between. The same 4 KB of storage is reachable through four aliased address windows. The window chosen by the requester decides how its opcode is read: plain access and counting, bit set, bit clear, or addition.

A set of hardware rings lives in the top 32 words of the store. Their head, tail and fill count are kept in internal registers. A put appends one word and a get removes the oldest. An empty get, a put to a full ring, a misaligned address and an undefined opcode are each reported in the response, and none of them disturbs the rings or the memory. Requesters present requests with a valid/ready handshake. A round-robin arbiter picks one at a time, and each accepted request gets exactly one tagged response.

Top module: `scratchpad_atomic`

## Requirements
- R1: The store holds 1024 32-bit words. A byte address is 14 bits: bits [11:2] select the word, and a read (window 0, opcode 0) returns the word last written there.
- R2: Address bits [13:12] pick the window: 0 plain/count/ring, 1 bit set, 2 bit clear, 3 add. A word written through one window is seen by all others.
- R3: In window 1, opcode 0 ORs the operand into the word and returns 0. Opcode 1 does the same but returns the prior word.
- R4: In window 2, opcode 0 clears the operand's set bits in the word and returns 0. Opcode 1 does the same but returns the prior word.
- R5: In window 3, opcode 0 adds the operand modulo 2^32 and returns 0. Opcode 1 does the same but returns the prior word.
- R6: In window 0, the opcodes are:
  - opcode 1 writes the operand and returns 0;
  - opcode 2 swaps in the operand and returns the prior word;
  - opcode 3 increments the word and returns the prior word;
  - opcode 4 decrements the word and returns the prior word.
  Increment and decrement wrap modulo 2^32.
- R7: Window 0, opcode 6 puts the operand on ring n, where n is address bits [3:2]. Each of the four rings holds 8 words in first-in first-out order, and its pointers wrap modulo 8.
- R8: Window 0, opcode 7 gets the oldest word of ring n. On an empty ring the response carries data 0 with the empty flag set, and the ring is unchanged.
- R9: A put to a ring holding 8 words is dropped and answered with the full flag. ring_full[n] is high exactly while ring n holds 8 words.
- R10: A request with address bits [1:0] non-zero, opcode 5 in window 0, or an opcode above 1 in windows 1 to 3 gets rsp_err with data 0, and it changes no word and no ring.
- R11: Each accepted request produces one response two clock edges after its acceptance edge, tagged with the requester index. No request is accepted on the edge right after an acceptance.
- R12: At most one requester is granted per cycle, and only one that is requesting. Among simultaneous requesters the grant rotates round-robin, starting from requester 0 after reset.
- R13: After reset, no response is valid and all ring_full bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request accepted at the next edge |
| req_op | input | 3*NREQ | Opcode per requester |
| req_addr | input | 14*NREQ | Byte address per requester (window in [13:12]) |
| req_wdata | input | 32*NREQ | Operand per requester |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NREQ) | Index of the requester being answered |
| rsp_data | output | 32 | Prior word, read data, ring word, or 0 |
| rsp_err | output | 1 | Misaligned address or undefined opcode |
| rsp_empty | output | 1 | Get found its ring empty |
| rsp_full | output | 1 | Put was dropped because its ring was full |
| ring_full | output | NRING | Per-ring full indication |

## Verification
The bench fills one ring past its capacity and then drains it past empty. A design that advanced the tail on a dropped put would return a stale or overwritten word later on. A design that moved the head on an empty get would lose the next message. A second round of puts and gets follows to drive both pointers through their wrap. An erroring request is always followed by a read of the same word, so a design that wrote memory despite the error is caught. An add of 2 to 0xFFFFFFFF and a decrement of zero expose carry mistakes, and the test forms are mixed with the plain forms to catch returned values that are swapped between the two. Both requesters run together so that any break in rotation or a second grant during the busy cycle shows at req_ready.

// File: rtl/scratchpad_pkg.sv
package scratchpad_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    WIN_RWS = 2'd0,
    WIN_SET = 2'd1,
    WIN_CLR = 2'd2,
    WIN_ADD = 2'd3
  } win_e;

  localparam logic [2:0] OP_RD    = 3'd0;
  localparam logic [2:0] OP_WR    = 3'd1;
  localparam logic [2:0] OP_SWAP  = 3'd2;
  localparam logic [2:0] OP_INC   = 3'd3;
  localparam logic [2:0] OP_DEC   = 3'd4;
  localparam logic [2:0] OP_PUT   = 3'd6;
  localparam logic [2:0] OP_GET   = 3'd7;
  localparam logic [2:0] OP_PLAIN = 3'd0;
  localparam logic [2:0] OP_TEST  = 3'd1;

  typedef struct packed {
    win_e          win;
    logic [2:0]    op;
    logic          misal;
    logic [DW-1:0] opnd;
  } cmd_t;
endpackage

// File: rtl/sp_arb.sv
module sp_arb #(
  parameter int N  = 2,
  parameter bit RR = 1'b1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  generate
    if (RR) begin : g_rr
      logic [IW-1:0] last_q;
      logic          found;

      always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
          int c;
          c = int'(last_q) + k;
          if (c >= N) c = c - N;
          if (!found && en && req[c]) begin
            found   = 1'b1;
            gnt[c]  = 1'b1;
            gnt_idx = IW'(c);
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          last_q <= IW'(N - 1);
        end else if (|gnt) begin
          last_q <= gnt_idx;
        end
      end
    end else begin : g_fixed
      logic found;

      always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
          if (!found && en && req[k]) begin
            found   = 1'b1;
            gnt[k]  = 1'b1;
            gnt_idx = IW'(k);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sp_alu.sv
module sp_alu
  import scratchpad_pkg::*;
(
  input  cmd_t          cmd,
  input  logic [DW-1:0] old,
  output logic [DW-1:0] new_val,
  output logic [DW-1:0] ret,
  output logic          wr_en,
  output logic          illegal,
  output logic          is_put,
  output logic          is_get
);
  logic test_form;
  assign test_form = (cmd.op == OP_TEST);

  always_comb begin
    new_val = old;
    ret     = '0;
    wr_en   = 1'b0;
    illegal = cmd.misal;
    is_put  = 1'b0;
    is_get  = 1'b0;
    unique case (cmd.win)
      WIN_RWS: begin
        case (cmd.op)
          OP_RD:   ret = old;
          OP_WR:   begin new_val = cmd.opnd;   wr_en = 1'b1; end
          OP_SWAP: begin new_val = cmd.opnd;   wr_en = 1'b1; ret = old; end
          OP_INC:  begin new_val = old + 1'b1; wr_en = 1'b1; ret = old; end
          OP_DEC:  begin new_val = old - 1'b1; wr_en = 1'b1; ret = old; end
          OP_PUT:  is_put = 1'b1;
          OP_GET:  is_get = 1'b1;
          default: illegal = 1'b1;
        endcase
      end
      WIN_SET: begin
        new_val = old | cmd.opnd;
        wr_en   = 1'b1;
        ret     = test_form ? old : '0;
        if (cmd.op > OP_TEST) illegal = 1'b1;
      end
      WIN_CLR: begin
        new_val = old & ~cmd.opnd;
        wr_en   = 1'b1;
        ret     = test_form ? old : '0;
        if (cmd.op > OP_TEST) illegal = 1'b1;
      end
      WIN_ADD: begin
        new_val = old + cmd.opnd;
        wr_en   = 1'b1;
        ret     = test_form ? old : '0;
        if (cmd.op > OP_TEST) illegal = 1'b1;
      end
      default: illegal = 1'b1;
    endcase
    if (illegal) begin
      wr_en  = 1'b0;
      ret    = '0;
      is_put = 1'b0;
      is_get = 1'b0;
    end
  end
endmodule

// File: rtl/sp_rings.sv
module sp_rings #(
  parameter int NRING = 4,
  parameter int DEPTH = 8,
  localparam int RW = $clog2(NRING),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    sel,
  input  logic             push,
  input  logic             pop,
  output logic [PW-1:0]    head_o,
  output logic [PW-1:0]    tail_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [NRING-1:0] full_vec
);
  logic [PW-1:0] head_a [NRING];
  logic [PW-1:0] tail_a [NRING];
  logic [PW:0]   cnt_a  [NRING];

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    logic [PW-1:0] head_q, head_d, tail_q, tail_d;
    logic [PW:0]   cnt_q, cnt_d;
    logic          push_r, pop_r, upd;

    assign push_r = push && (sel == RW'(r));
    assign pop_r  = pop  && (sel == RW'(r));
    assign upd    = push_r || pop_r;

    always_comb begin
      head_d = head_q;
      tail_d = tail_q;
      cnt_d  = cnt_q;
      if (push_r) begin
        tail_d = tail_q + 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
      if (pop_r) begin
        head_d = head_q + 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        tail_q <= '0;
        cnt_q  <= '0;
      end else if (upd) begin
        head_q <= head_d;
        tail_q <= tail_d;
        cnt_q  <= cnt_d;
      end
    end

    assign head_a[r]   = head_q;
    assign tail_a[r]   = tail_q;
    assign cnt_a[r]    = cnt_q;
    assign full_vec[r] = (cnt_q == (PW+1)'(DEPTH));
  end

  assign head_o  = head_a[sel];
  assign tail_o  = tail_a[sel];
  assign empty_o = (cnt_a[sel] == '0);
  assign full_o  = full_vec[sel];
endmodule

// File: rtl/scratchpad_atomic.sv
module scratchpad_atomic
  import scratchpad_pkg::*;
#(
  parameter int NREQ   = 2,
  parameter int WORDS  = 1024,
  parameter int NRING  = 4,
  parameter int RDEPTH = 8,
  parameter bit ARB_RR = 1'b1,
  localparam int IW  = $clog2(WORDS),
  localparam int AW  = IW + 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  output logic [NREQ-1:0]    req_ready,
  input  logic [NREQ*3-1:0]  req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [IDW-1:0]     rsp_id,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_err,
  output logic               rsp_empty,
  output logic               rsp_full,
  output logic [NRING-1:0]   ring_full
);
  localparam int RW    = $clog2(NRING);
  localparam int PW    = $clog2(RDEPTH);
  localparam int RBASE = WORDS - NRING * RDEPTH;
  localparam logic [IW-1:0] RBASE_W = IW'(RBASE);

  // accept stage
  logic [NREQ-1:0] gnt;
  logic [IDW-1:0]  gnt_idx;
  logic            busy_q, busy_d, accept;
  cmd_t            cmd_q, cmd_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [IDW-1:0]  id_q;
  logic [AW-1:0]   sel_addr;

  sp_arb #(.N(NREQ), .RR(ARB_RR)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .en(!busy_q),
    .gnt(gnt), .gnt_idx(gnt_idx)
  );

  assign req_ready = gnt;
  assign accept    = |gnt;
  assign busy_d    = busy_q ? 1'b0 : accept;

  always_comb begin
    sel_addr   = req_addr[int'(gnt_idx)*AW +: AW];
    cmd_d.win  = win_e'(sel_addr[AW-1:AW-2]);
    cmd_d.op   = req_op[int'(gnt_idx)*3 +: 3];
    cmd_d.misal = |sel_addr[1:0];
    cmd_d.opnd = req_wdata[int'(gnt_idx)*DW +: DW];
    idx_d      = sel_addr[IW+1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      idx_q <= '0;
      id_q  <= '0;
    end else if (accept) begin
      cmd_q <= cmd_d;
      idx_q <= idx_d;
      id_q  <= gnt_idx;
    end
  end

  // execute stage: read, modify, write in the busy cycle
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] old_w, new_w, ret_w, wval;
  logic          alu_wr, illegal, is_put, is_get;
  logic          do_put, do_get, mem_we;
  logic [RW-1:0] ring_sel;
  logic [PW-1:0] head, tail;
  logic          r_empty, r_full;
  logic [IW-1:0] rd_idx, wr_idx;

  assign ring_sel = idx_q[RW-1:0];

  sp_alu u_alu (
    .cmd(cmd_q), .old(old_w), .new_val(new_w), .ret(ret_w),
    .wr_en(alu_wr), .illegal(illegal), .is_put(is_put), .is_get(is_get)
  );

  sp_rings #(.NRING(NRING), .DEPTH(RDEPTH)) u_rings (
    .clk(clk), .rst_n(rst_n), .sel(ring_sel), .push(do_put), .pop(do_get),
    .head_o(head), .tail_o(tail), .empty_o(r_empty), .full_o(r_full),
    .full_vec(ring_full)
  );

  assign do_put = busy_q && is_put && !r_full;
  assign do_get = busy_q && is_get && !r_empty;

  always_comb begin
    rd_idx = is_get ? RBASE_W + {{(IW-RW-PW){1'b0}}, ring_sel, head} : idx_q;
    wr_idx = is_put ? RBASE_W + {{(IW-RW-PW){1'b0}}, ring_sel, tail} : idx_q;
    old_w  = mem_q[rd_idx];
    wval   = is_put ? cmd_q.opnd : new_w;
    mem_we = busy_q && (alu_wr || do_put);
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem_q[wr_idx] <= wval;
    end
  end

  // response stage
  logic [DW-1:0] rdata_d;
  always_comb begin
    rdata_d = ret_w;
    if (is_get) rdata_d = do_get ? old_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_empty <= 1'b0;
      rsp_full  <= 1'b0;
    end else begin
      rsp_valid <= busy_q;
      rsp_err   <= busy_q && illegal;
      rsp_empty <= busy_q && is_get && r_empty;
      rsp_full  <= busy_q && is_put && r_full;
      if (busy_q) begin
        rsp_id   <= id_q;
        rsp_data <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/scratchpad_atomic_chk.sv
module scratchpad_atomic_chk #(
  parameter int NREQ  = 2,
  parameter int NRING = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_valid,
  input logic [NREQ-1:0]  req_ready,
  input logic             rsp_valid,
  input logic [31:0]      rsp_data,
  input logic             rsp_err,
  input logic             rsp_empty,
  input logic             rsp_full,
  input logic [NRING-1:0] ring_full
);
  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  assert_grant_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  assert_stall_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (req_ready == '0));

  assert_rsp_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> ##2 rsp_valid);

  assert_rsp_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(|req_ready, 2));

  assert_flags_need_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_err || rsp_empty || rsp_full));

  assert_err_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0 && !rsp_empty && !rsp_full));

  assert_empty_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_empty) |-> (rsp_data == '0));

  assert_drop_keeps_rings_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_full) |-> ($stable(ring_full) && ring_full != '0));
endmodule

bind scratchpad_atomic scratchpad_atomic_chk #(.NREQ(NREQ), .NRING(NRING)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .rsp_empty(rsp_empty), .rsp_full(rsp_full), .ring_full(ring_full)
);

// File: tb/scratchpad_atomic_tb_top.sv
`timescale 1ns/1ps
module scratchpad_atomic_tb_top;
  localparam int NREQ = 2, AW = 14, NRING = 4, RDEPTH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [NREQ-1:0]    req_valid, req_ready;
  logic [NREQ*3-1:0]  req_op;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ*32-1:0] req_wdata;
  logic rsp_valid, rsp_err, rsp_empty, rsp_full;
  logic [0:0]  rsp_id;
  logic [31:0] rsp_data;
  logic [NRING-1:0] ring_full;

  scratchpad_atomic dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .rsp_empty(rsp_empty), .rsp_full(rsp_full),
    .ring_full(ring_full)
  );

  typedef struct { logic [2:0] op; logic [13:0] addr; logic [31:0] d; } rq_t;
  typedef struct { bit v; int id; logic [31:0] data; bit err, empty, full; string tag; } pend_t;

  rq_t qs [NREQ][$];
  logic [31:0] mm [int];
  logic [31:0] rings [NRING][$];
  int checks = 0, fails = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int who, int win, int op, int idx, logic [31:0] d, int lowbits = 0);
    rq_t r;
    r.op = 3'(op);
    r.addr = {2'(win), 10'(idx), 2'(lowbits)};
    r.d = d;
    qs[who].push_back(r);
  endtask

  function automatic pend_t model(int id, rq_t r);
    pend_t p;
    int win, op, idx, rn;
    logic [31:0] old;
    win = int'(r.addr[13:12]); op = int'(r.op); idx = int'(r.addr[11:2]);
    rn = int'(r.addr[3:2]);
    p.v = 1; p.id = id; p.data = 0; p.err = 0; p.empty = 0; p.full = 0;
    old = mm.exists(idx) ? mm[idx] : 32'h0;
    if (r.addr[1:0] != 0 || (win == 0 && op == 5) || (win != 0 && op > 1)) begin
      p.err = 1; p.tag = "R10"; return p;
    end
    case (win)
      0: case (op)
        0: begin p.data = old; p.tag = "R1"; end
        1: begin mm[idx] = r.d; p.tag = "R6"; end
        2: begin mm[idx] = r.d; p.data = old; p.tag = "R6"; end
        3: begin mm[idx] = old + 1; p.data = old; p.tag = "R6"; end
        4: begin mm[idx] = old - 1; p.data = old; p.tag = "R6"; end
        6: begin
             p.tag = "R7";
             if (rings[rn].size() == RDEPTH) begin p.full = 1; p.tag = "R9"; end
             else rings[rn].push_back(r.d);
           end
        default: begin
             p.tag = "R8";
             if (rings[rn].size() == 0) p.empty = 1;
             else p.data = rings[rn].pop_front();
           end
      endcase
      1: begin mm[idx] = old | r.d;  p.data = (op == 1) ? old : 0; p.tag = "R3 R2"; end
      2: begin mm[idx] = old & ~r.d; p.data = (op == 1) ? old : 0; p.tag = "R4 R2"; end
      default: begin mm[idx] = old + r.d; p.data = (op == 1) ? old : 0; p.tag = "R5 R2"; end
    endcase
    return p;
  endfunction

  function automatic logic [NRING-1:0] full_now();
    logic [NRING-1:0] f;
    for (int i = 0; i < NRING; i++) f[i] = (rings[i].size() == RDEPTH);
    return f;
  endfunction

  task automatic drive();
    for (int i = 0; i < NREQ; i++) begin
      if (qs[i].size() > 0) begin
        req_valid[i] = 1'b1;
        req_op[i*3 +: 3]     = qs[i][0].op;
        req_addr[i*AW +: AW] = qs[i][0].addr;
        req_wdata[i*32 +: 32] = qs[i][0].d;
      end else begin
        req_valid[i] = 1'b0;
      end
    end
  endtask

  initial begin
    pend_t p1, p2, none;
    logic [NRING-1:0] f1, f2;
    int last, acc;
    bit done;
    logic [NREQ-1:0] exp_rdy;

    none.v = 0; none.id = 0; none.data = 0; none.err = 0; none.empty = 0; none.full = 0; none.tag = "";
    p1 = none; p2 = none; f1 = '0; f2 = '0; last = NREQ - 1; done = 0;
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R13 rsp_valid", 32'(rsp_valid), 0);
    chk(ring_full == '0, "R13 ring_full", 32'(ring_full), 0);
    chk(req_ready == '0, "R13 req_ready", 32'(req_ready), 0);
    rst_n = 1'b1;

    // requester 0: word operations through all windows
    push(0, 0, 1, 5, 32'h1234_5678);
    push(0, 0, 0, 5, 0);
    push(0, 0, 2, 5, 32'hAAAA_0000);
    push(0, 0, 0, 5, 0);
    push(0, 0, 3, 5, 0);
    push(0, 0, 4, 5, 0);
    push(0, 0, 4, 5, 0);
    push(0, 1, 0, 5, 32'h0000_000F);
    push(0, 1, 1, 5, 32'h0000_00F0);
    push(0, 2, 0, 5, 32'h0000_0003);
    push(0, 2, 1, 5, 32'h0000_000C);
    push(0, 0, 0, 5, 0);
    push(0, 0, 1, 6, 32'hFFFF_FFFF);
    push(0, 3, 1, 6, 32'd2);
    push(0, 3, 0, 6, 32'd7);
    push(0, 0, 0, 6, 0);
    push(0, 0, 1, 6, 32'd99, 2);
    push(0, 1, 3, 6, 32'hFFFF_FFFF);
    push(0, 0, 5, 6, 0);
    push(0, 2, 2, 6, 32'hFFFF_FFFF);
    push(0, 0, 0, 6, 0);
    push(0, 0, 1, 7, 0);
    push(0, 0, 4, 7, 0);
    push(0, 0, 0, 7, 0);
    // requester 1: rings, with a word op for contention
    push(1, 0, 1, 20, 32'hC0DE_0001);
    for (int i = 0; i < 9; i++) push(1, 0, 6, 1, 32'h100 + i);
    push(1, 0, 6, 2, 32'h2000);
    push(1, 0, 7, 2, 0);
    for (int i = 0; i < 9; i++) push(1, 0, 7, 1, 0);
    push(1, 0, 6, 1, 32'h0, 1);
    for (int i = 0; i < 3; i++) push(1, 0, 6, 1, 32'h300 + i);
    for (int i = 0; i < 4; i++) push(1, 0, 7, 1, 0);
    push(1, 0, 0, 20, 0);

    @(posedge clk); #1; drive();

    for (int cyc = 0; cyc < 5000 && !done; cyc++) begin
      @(negedge clk);
      // arbitration model
      exp_rdy = '0; acc = -1;
      if (!p1.v) begin
        for (int k = 1; k <= NREQ; k++) begin
          int c;
          c = (last + k) % NREQ;
          if (acc < 0 && qs[c].size() > 0) acc = c;
        end
        if (acc >= 0) begin exp_rdy[acc] = 1'b1; last = acc; end
      end
      chk(req_ready == exp_rdy, "R12 grant", 32'(req_ready), 32'(exp_rdy));
      chk(rsp_valid == p2.v, "R11 rsp_valid", 32'(rsp_valid), 32'(p2.v));
      if (p2.v && rsp_valid) begin
        chk(int'(rsp_id) == p2.id, "R11 rsp_id", 32'(rsp_id), 32'(p2.id));
        chk(rsp_data == p2.data, p2.tag, rsp_data, p2.data);
        chk(rsp_err == p2.err, "R10 err flag", 32'(rsp_err), 32'(p2.err));
        chk(rsp_empty == p2.empty, "R8 empty flag", 32'(rsp_empty), 32'(p2.empty));
        chk(rsp_full == p2.full, "R9 full flag", 32'(rsp_full), 32'(p2.full));
      end
      chk(ring_full == f2, "R9 ring_full", 32'(ring_full), 32'(f2));
      p2 = p1;
      p1 = (acc >= 0) ? model(acc, qs[acc][0]) : none;
      f2 = f1;
      f1 = full_now();
      done = (qs[0].size() == 0 && qs[1].size() == 0 && !p1.v && !p2.v);
      @(posedge clk); #1;
      if (acc >= 0) void'(qs[acc].pop_front());
      drive();
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 32'(0), 32'(1));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule